// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block takes interrupt events from on-chip sources and stores each one as a 16-byte vector in a circular buffer in memory. Host software drains that buffer. The block keeps a byte-granular write pointer. The host moves a byte-granular read pointer through a small register port. The ring is empty when the two pointers are equal.

Each accepted event becomes four single-word memory write requests. The write pointer advances only after the last of the four words has been acknowledged, so the host never sees the pointer cover data that has not been written yet.

When the ring is full, a new vector still overwrites the oldest slot. If detection is enabled, a sticky overflow flag appears in the top bit of the write-pointer value. The host recovers by restarting one vector past the write pointer. The block can also copy every new write-pointer value to a programmed memory word, and it drives one level-sensitive interrupt line.

Top module: `ivr_producer`

## Requirements
- R1: For each accepted event the block issues four word writes, in order, at byte addresses {base,8'h00} + wptr + 0, 4, 8 and 12. The words are:
  - word 0 is {24'b0, source id};
  - word 1 is {4'b0, 28-bit source data};
  - word 2 is {PASID[15:0], VM id[7:0], ring id[7:0]};
  - word 3 is zero.
- R2: After the fourth word is acknowledged, the write pointer becomes (wptr + 16) & mask. The mask is 2^(size+2) - 1, where size is CTRL[12:8] and gives log2 of the ring length in 32-bit words.
- R3: An event accepted while (wptr + 16) & mask equals rptr is still written and still advances the pointer.
  - If CTRL[2] (overflow detect) is set, bit 31 of the write-pointer value becomes 1 and stays 1.
  - Writing CTRL with bit 3 set clears that bit.
- R4: While CTRL[4] (writeback) is set, each vector is followed by one extra word write of the updated write-pointer value, including bit 31, to address {WBHI[7:0], WBLO}. With CTRL[4] clear, no extra write is made.
- R5: The irq output rises when a vector is committed into an empty ring while CTRL[0] is set. Any read-pointer write drops irq, unless CTRL[5] (rearm) is set and the new read pointer differs from the write pointer, in which case irq is 1.
- R6: Writing CTRL with bit 1 (ring enable) clear does all of the following:
  - resets both pointers to 0;
  - drops irq and ev_ready;
  - causes read-pointer writes to be ignored while the ring stays disabled.
- R7: ev_ready is high only while the ring is enabled and no memory write is outstanding.
  - busy is high from acceptance until the last write is acknowledged.
  - mem_req, mem_addr and mem_data hold until mem_ack.
- R8: After reset:
  - CTRL reads 0x00000E00 (size 14, which is a 64 KiB ring);
  - both pointers read 0;
  - irq, busy, ev_ready and mem_req are low.
- R9: With CTRL[0] clear, irq stays low whatever vectors are written.
- R10: The register addresses are 0 CTRL, 1 BASE (address bits [39:8]), 2 RPTR, 3 WPTR (bit 31 overflow, low bits pointer, read only), 4 WBLO and 5 WBHI.
  - The CTRL bits are [0] interrupt enable, [1] ring enable, [2] overflow detect, [3] overflow clear, [4] writeback and [5] rearm.
  - Bit 3 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vm | input | 8 | VM id |
| ev_pasid | input | 16 | Process address space id |
| mem_req | output | 1 | Memory word write request |
| mem_addr | output | 40 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write accepted this cycle |
| irq | output | 1 | Interrupt line |
| busy | output | 1 | Memory writes outstanding |

## Verification
An event is taken on the edge where ev_valid and ev_ready are both high. With an acknowledge on every request, the four vector words go out on the next four edges. The pointer, the overflow flag and irq change on the edge that acknowledges word 3, and the writeback word follows on the edge after that. Register writes take effect on the edge that samples the strobe, and reads are combinational. The checks therefore wait on a falling edge until busy drops, and only then read the memory log, the registers and irq. One stalled-acknowledge case holds the request for several cycles so that the hold behaviour can be observed.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int VEC_BYTES = 16;
    localparam int ADDR_W    = 40;
    localparam int OVF_BIT   = 31;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_BASE = 3'd1;
    localparam logic [2:0] RA_RPTR = 3'd2;
    localparam logic [2:0] RA_WPTR = 3'd3;
    localparam logic [2:0] RA_WBLO = 3'd4;
    localparam logic [2:0] RA_WBHI = 3'd5;

    typedef enum logic [1:0] {SQ_IDLE, SQ_VEC, SQ_WB} seq_st_e;

    typedef struct packed {
        logic        intr_en;
        logic        ring_en;
        logic        ovf_det;
        logic        wb_en;
        logic        rearm;
        logic [4:0]  size_lg;
        logic [31:0] base;
        logic [31:0] wb_lo;
        logic [7:0]  wb_hi;
        logic        ovf;
        logic        irq;
    } ctl_t;

    typedef struct packed {
        seq_st_e     st;
        logic [1:0]  idx;
        logic        full;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] w2;
        logic [ADDR_W-1:0] vaddr;
    } seq_t;
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W    = 18,
    parameter int SIZE_RST = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              commit,
    input  logic              commit_full,
    output logic [31:0]       base_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic [31:0]       wptr_word_o,
    output logic [PTR_W-1:0]  wptr_o,
    output logic              full_o,
    output logic              ring_en_o,
    output logic              wb_en_o,
    output logic              irq_o
);
    localparam int PAD_W = 31 - PTR_W;

    ctl_t             c_d, c_q;
    logic [PTR_W-1:0] wptr_d, wptr_q, rptr_d, rptr_q;
    logic [PTR_W-1:0] mask, next_w;
    logic             empty;

    // ring byte mask from the log2 word count
    always_comb begin
        for (int b = 0; b < PTR_W; b++) begin
            mask[b] = (b < (int'(c_q.size_lg) + 2));
        end
        next_w = (wptr_q + PTR_W'(VEC_BYTES)) & mask;
        empty  = (wptr_q == rptr_q);
        full_o = (next_w == rptr_q);
    end

    always_comb begin
        c_d    = c_q;
        wptr_d = wptr_q;
        rptr_d = rptr_q;
        if (commit && c_q.ring_en) begin
            wptr_d = next_w;
            if (commit_full && c_q.ovf_det) c_d.ovf = 1'b1;
            if (empty && c_q.intr_en)       c_d.irq = 1'b1;
        end
        if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    c_d.intr_en = reg_wdata[0];
                    c_d.ring_en = reg_wdata[1];
                    c_d.ovf_det = reg_wdata[2];
                    c_d.wb_en   = reg_wdata[4];
                    c_d.rearm   = reg_wdata[5];
                    c_d.size_lg = reg_wdata[12:8];
                    if (reg_wdata[3])  c_d.ovf = 1'b0;
                    if (!reg_wdata[0]) c_d.irq = 1'b0;
                    if (!reg_wdata[1]) begin
                        wptr_d  = '0;
                        rptr_d  = '0;
                        c_d.irq = 1'b0;
                    end
                end
                RA_BASE: c_d.base = reg_wdata;
                RA_RPTR: begin
                    if (c_q.ring_en) begin
                        rptr_d  = reg_wdata[PTR_W-1:0] & mask;
                        c_d.irq = c_q.intr_en && c_q.rearm && (rptr_d != wptr_d);
                    end
                end
                RA_WBLO: c_d.wb_lo = reg_wdata;
                RA_WBHI: c_d.wb_hi = reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q         <= '0;
            c_q.size_lg <= 5'(SIZE_RST);
            wptr_q      <= '0;
            rptr_q      <= '0;
        end else begin
            c_q    <= c_d;
            wptr_q <= wptr_d;
            rptr_q <= rptr_d;
        end
    end

    always_comb begin
        wptr_word_o = {c_q.ovf, {PAD_W{1'b0}}, wptr_q};
        case (reg_addr)
            RA_CTRL: reg_rdata = {19'd0, c_q.size_lg, 2'd0, c_q.rearm, c_q.wb_en,
                                  1'b0, c_q.ovf_det, c_q.ring_en, c_q.intr_en};
            RA_BASE: reg_rdata = c_q.base;
            RA_RPTR: reg_rdata = {{(32-PTR_W){1'b0}}, rptr_q};
            RA_WPTR: reg_rdata = wptr_word_o;
            RA_WBLO: reg_rdata = c_q.wb_lo;
            RA_WBHI: reg_rdata = {24'd0, c_q.wb_hi};
            default: reg_rdata = '0;
        endcase
    end

    assign base_o    = c_q.base;
    assign wb_addr_o = {c_q.wb_hi, c_q.wb_lo};
    assign wptr_o    = wptr_q;
    assign ring_en_o = c_q.ring_en;
    assign wb_en_o   = c_q.wb_en;
    assign irq_o     = c_q.irq;

    // R2: the write pointer always sits on a vector boundary
    p_wptr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_q[3:0] == 4'd0);
    // R6: a disabled ring holds both pointers at zero
    p_disabled_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.ring_en |-> (wptr_q == '0 && rptr_q == '0));
    // R9: the line never stands without interrupt enable
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.irq |-> c_q.intr_en);
    // R3: overflow only rises after a commit into a full ring
    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.ovf) |-> $past(commit && commit_full));
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [7:0]        ev_src,
    input  logic [27:0]       ev_data,
    input  logic [7:0]        ev_ring,
    input  logic [7:0]        ev_vm,
    input  logic [15:0]       ev_pasid,
    input  logic              ring_en,
    input  logic              wb_en,
    input  logic              full,
    input  logic [31:0]       base,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [31:0]       wptr_word,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    input  logic              mem_ack,
    output logic              commit,
    output logic              commit_full,
    output logic              busy
);
    seq_t s_d, s_q;
    logic accept;
    logic last;

    always_comb begin
        s_d         = s_q;
        ev_ready    = ring_en && (s_q.st == SQ_IDLE);
        accept      = ev_valid && ev_ready;
        busy        = (s_q.st != SQ_IDLE);
        mem_req     = busy;
        commit      = 1'b0;
        commit_full = s_q.full;
        last        = (s_q.idx == 2'd3);
        mem_addr    = s_q.vaddr + {36'd0, s_q.idx, 2'b00};
        case (s_q.idx)
            2'd0:    mem_data = s_q.w0;
            2'd1:    mem_data = s_q.w1;
            2'd2:    mem_data = s_q.w2;
            default: mem_data = '0;
        endcase
        case (s_q.st)
            SQ_IDLE: begin
                if (accept) begin
                    s_d.st    = SQ_VEC;
                    s_d.idx   = 2'd0;
                    s_d.full  = full;
                    s_d.w0    = {24'd0, ev_src};
                    s_d.w1    = {4'd0, ev_data};
                    s_d.w2    = {ev_pasid, ev_vm, ev_ring};
                    s_d.vaddr = {base, 8'h00} + {{(ADDR_W-PTR_W){1'b0}}, wptr};
                end
            end
            SQ_VEC: begin
                if (mem_ack) begin
                    if (last) begin
                        commit = 1'b1;
                        s_d.st = wb_en ? SQ_WB : SQ_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + 2'd1;
                    end
                end
            end
            SQ_WB: begin
                mem_addr = wb_addr;
                mem_data = wptr_word;
                if (mem_ack) s_d.st = SQ_IDLE;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: an unacknowledged request holds address and data
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));
    // R7: an accepted event makes the block busy on the next cycle
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
    import ivr_pkg::*;
#(
    parameter int PTR_W    = 18,
    parameter int SIZE_RST = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ev_valid,
    output logic        ev_ready,
    input  logic [7:0]  ev_src,
    input  logic [27:0] ev_data,
    input  logic [7:0]  ev_ring,
    input  logic [7:0]  ev_vm,
    input  logic [15:0] ev_pasid,
    output logic        mem_req,
    output logic [39:0] mem_addr,
    output logic [31:0] mem_data,
    input  logic        mem_ack,
    output logic        irq,
    output logic        busy
);
    logic [31:0]       base_w, wptr_word_w;
    logic [ADDR_W-1:0] wb_addr_w;
    logic [PTR_W-1:0]  wptr_w;
    logic              full_w, ring_en_w, wb_en_w, commit_w, commit_full_w;

    ivr_regs #(.PTR_W(PTR_W), .SIZE_RST(SIZE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .commit(commit_w), .commit_full(commit_full_w),
        .base_o(base_w), .wb_addr_o(wb_addr_w), .wptr_word_o(wptr_word_w),
        .wptr_o(wptr_w), .full_o(full_w), .ring_en_o(ring_en_w), .wb_en_o(wb_en_w),
        .irq_o(irq)
    );

    ivr_seq #(.PTR_W(PTR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vm(ev_vm), .ev_pasid(ev_pasid),
        .ring_en(ring_en_w), .wb_en(wb_en_w), .full(full_w),
        .base(base_w), .wptr(wptr_w), .wb_addr(wb_addr_w), .wptr_word(wptr_word_w),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .commit(commit_w), .commit_full(commit_full_w), .busy(busy)
    );
endmodule

// File: tb/ivr_producer_test.sv
module ivr_producer_test;
    typedef struct packed {
        logic [7:0]  src;
        logic [27:0] dat;
        logic [7:0]  rng;
        logic [7:0]  vm;
        logic [15:0] pas;
        logic [31:0] exp_w;
    } vec_t;

    localparam vec_t TBL [4] = '{
        '{8'h11, 28'h0ABCDEF, 8'h01, 8'h02, 16'h1234, 32'h0000_0010},
        '{8'hA5, 28'hFFFFFFF, 8'h7F, 8'h80, 16'hFFFF, 32'h0000_0020},
        '{8'h00, 28'h0000001, 8'hFF, 8'h00, 16'h0001, 32'h0000_0030},
        '{8'hFE, 28'h5A5A5A5, 8'h33, 8'hCC, 16'hBEEF, 32'h8000_0000}
    };
    localparam logic [39:0] BASEA = 40'h12_3456_7800;
    localparam logic [39:0] WBA   = 40'h05_0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [7:0]  ev_src = 8'd0;
    logic [27:0] ev_data = 28'd0;
    logic [7:0]  ev_ring = 8'd0;
    logic [7:0]  ev_vm = 8'd0;
    logic [15:0] ev_pasid = 16'd0;
    logic        mem_req;
    logic [39:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ack;
    logic        irq;
    logic        busy;
    logic        ack_en = 1'b0;

    int tests = 0;
    int fails = 0;
    int n = 0;
    logic [39:0] log_addr [64];
    logic [31:0] log_data [64];

    always #4 clk = ~clk;
    assign mem_ack = mem_req & ack_en;

    ivr_producer uut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vm(ev_vm), .ev_pasid(ev_pasid),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .irq(irq), .busy(busy)
    );

    always @(negedge clk) begin
        if (mem_req && mem_ack && n < 64) begin
            log_addr[n] = mem_addr;
            log_data[n] = mem_data;
            n = n + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_ev(input vec_t v);
        @(posedge clk); #1;
        ev_src = v.src; ev_data = v.dat; ev_ring = v.rng; ev_vm = v.vm; ev_pasid = v.pas;
        ev_valid = 1'b1;
        do @(negedge clk); while (!ev_ready);
        @(posedge clk); #1;
        ev_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    function automatic logic [31:0] exp_word(input vec_t v, input int k);
        case (k)
            0:       return {24'd0, v.src};
            1:       return {4'd0, v.dat};
            2:       return {v.pas, v.vm, v.rng};
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int n0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        ack_en = 1'b1;

        // R8 reset state
        reg_rd(3'd0, rd); chk("R8 ctrl reset", rd, 32'h0000_0E00);
        reg_rd(3'd3, rd); chk("R8 wptr reset", rd, 32'd0);
        reg_rd(3'd2, rd); chk("R8 rptr reset", rd, 32'd0);
        @(negedge clk);
        chk("R8 irq reset", irq, 1'b0);
        chk("R8 busy reset", busy, 1'b0);
        chk("R8 ready reset", ev_ready, 1'b0);
        chk("R8 req reset", mem_req, 1'b0);

        reg_wr(3'd1, 32'h1234_5678);
        reg_wr(3'd4, 32'h0000_1000);
        reg_wr(3'd5, 32'h0000_0005);
        reg_wr(3'd0, 32'h0000_0417);   // size 4 -> 64-byte ring, four slots

        // R1 R2 R3 R4: table of vectors; the last lands in a full ring
        for (int i = 0; i < 4; i++) begin
            n0 = n;
            send_ev(TBL[i]);
            wait_idle();
            for (int k = 0; k < 4; k++) begin
                chk("R1 word addr", log_addr[n0+k], BASEA + 40'(16*i + 4*k));
                chk("R1 word data", log_data[n0+k], exp_word(TBL[i], k));
            end
            chk("R4 wb addr", log_addr[n0+4], WBA);
            chk("R4 wb data", log_data[n0+4], TBL[i].exp_w);
            chk("R4 write count", n, n0 + 5);
            reg_rd(3'd3, rd); chk("R2 R3 wptr value", rd, TBL[i].exp_w);
            if (i == 0) chk("R5 irq on first vector", irq, 1'b1);
        end

        // R3 R10 overflow clear, clear bit reads back 0
        reg_wr(3'd0, 32'h0000_041F);
        reg_rd(3'd3, rd); chk("R3 ovf cleared", rd, 32'd0);
        reg_rd(3'd0, rd); chk("R10 ctrl readback", rd, 32'h0000_0417);

        // R5 read-pointer write without rearm drops irq
        reg_wr(3'd2, 32'd16);
        reg_rd(3'd2, rd); chk("R10 rptr readback", rd, 32'd16);
        chk("R5 irq drop no rearm", irq, 1'b0);
        // R5 rearm
        reg_wr(3'd0, 32'h0000_0437);
        reg_wr(3'd2, 32'd32);
        chk("R5 rearm unequal", irq, 1'b1);
        reg_wr(3'd2, 32'd0);
        chk("R5 rearm equal", irq, 1'b0);

        // R7 stalled memory
        ack_en = 1'b0;
        n0 = n;
        send_ev(TBL[1]);
        repeat (5) @(negedge clk);
        chk("R7 busy in stall", busy, 1'b1);
        chk("R7 ready low in stall", ev_ready, 1'b0);
        chk("R7 req held", mem_req, 1'b1);
        chk("R7 addr held", mem_addr, BASEA);
        chk("R7 no transfer", n, n0);
        ack_en = 1'b1;
        wait_idle();
        chk("R7 writes after stall", n, n0 + 5);
        chk("R5 irq into empty ring", irq, 1'b1);
        reg_rd(3'd3, rd); chk("R2 wptr after stall", rd, 32'd16);

        // R9 interrupt disabled
        reg_wr(3'd0, 32'h0000_0416);
        reg_wr(3'd2, 32'd16);
        send_ev(TBL[2]);
        wait_idle();
        chk("R9 irq stays low", irq, 1'b0);
        reg_rd(3'd3, rd); chk("R2 wptr no intr", rd, 32'd32);

        // R4 writeback off
        reg_wr(3'd0, 32'h0000_0406);
        n0 = n;
        send_ev(TBL[0]);
        wait_idle();
        chk("R4 no writeback", n, n0 + 4);
        reg_rd(3'd3, rd); chk("R2 wptr wb off", rd, 32'd48);

        // R6 disable
        reg_wr(3'd0, 32'h0000_0400);
        reg_rd(3'd3, rd); chk("R6 wptr zero", rd, 32'd0);
        reg_rd(3'd2, rd); chk("R6 rptr zero", rd, 32'd0);
        chk("R6 ready low", ev_ready, 1'b0);
        chk("R6 irq low", irq, 1'b0);
        reg_wr(3'd2, 32'd32);
        reg_rd(3'd2, rd); chk("R6 rptr write ignored", rd, 32'd0);

        // R2 larger ring: size 5 -> 128 bytes, no wrap after four vectors
        reg_wr(3'd0, 32'h0000_0502);
        reg_rd(3'd0, rd); chk("R10 ctrl size5", rd, 32'h0000_0502);
        for (int j = 0; j < 4; j++) begin
            send_ev(TBL[j]);
            wait_idle();
        end
        reg_rd(3'd3, rd); chk("R2 size5 wptr", rd, 32'd64);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule